// File: doc/BRIEF.md
# General-Purpose I/O Register Bank

A bank of general-purpose I/O lines steered through a small register window. Each register is as wide as the bank, so the line count is the register width (8, 16, 32 or 64). A plain request port (valid, write flag, word offset, write data) reaches five registers. The first is a load register: a write loads every output level at once, and a read returns the pad levels seen through a two-flop synchronizer. The second and third are a write-one-to-raise register and a write-one-to-lower register; each touches only the lines whose bits are 1. Last come an output-enable register and its complement, an input-select register. Both read from one direction state, so they can never disagree.

Reads answer one cycle after the request, with a response strobe. Writes give no response. Two elaboration options change how a bus word maps to the lines. Mirrored numbering places line n at register bit WIDTH-1-n. Byte-swapped access reverses the byte order of every word on the bus, and is accepted only at 16 and 32 bits.

The bank has no states: each write moves the output latch or the direction state in one step, and each read fills the response register in one step.

Top module: `gpio_mmio_bank`

## Requirements
- R1: After reset, pad_out and pad_oe are all zero. A read of the output-enable register (offset 3) returns zero, and a read of the input-select register (offset 4) returns all ones.
- R2: A write to offset 0 loads the output level of every line from the write data. The new levels are on pad_out in the cycle after the write edge.
- R3: A write to offset 1 drives high each line whose data bit is 1. Lines whose bit is 0 keep their level.
- R4: A write to offset 2 drives low each line whose data bit is 1. Lines whose bit is 0 keep their level.
- R5: A write to offset 3 sets pad_oe to the data, where 1 means output. Afterwards offset 4 reads as the bitwise complement of the data.
- R6: A write to offset 4 marks as inputs the lines whose bit is 1, and pad_oe becomes the complement of the data. Afterwards offset 3 reads as the complement of the data.
- R7: A read of offset 0 returns the pad_in levels delayed by two flops. A pad change made just before clock edge k first shows in a read sampled at edge k+2, whatever the line direction.
- R8: A read of offset 1 returns the output latch, whatever the pad levels are.
- R9: Reads of offset 2 and of offsets 5 to 7 return zero. Writes to offsets 5 to 7 change neither pad_out nor pad_oe.
- R10: With MIRROR set, line n is carried by bus bit WIDTH-1-n, both on writes and on reads.
- R11: With BYTE_SWAP set at 16 or 32 bits, byte b of a bus word holds line byte NBYTES-1-b, both on writes and on reads. At 8 or 64 bits the option is dropped and the mapping stays straight.
- R12: rsp_valid is high in exactly the cycle after a read request. rsp_rdata changes only on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register offset in words |
| bus_wdata | input | WIDTH | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_rdata | output | WIDTH | Read data |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Output levels toward the pads |
| pad_oe | output | WIDTH | Output enables toward the pads |

## Verification
On every cycle, the embedded properties check several relations. A raise write never lowers a line, and a lower write never raises one. A load write copies the data exactly. Idle cycles leave both the latch and the direction state alone. The synchronizer output equals the pad value from two edges earlier. The response strobe follows read requests exactly, and unmapped reads return zero. The bench scenarios cover what those properties cannot see. These are the bus-to-line bit permutations of the mirrored and byte-swapped variants, the complement readback of the direction pair, and the exact read in which a pad change first appears.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    localparam int OFS_LOAD  = 0;
    localparam int OFS_RAISE = 1;
    localparam int OFS_LOWER = 2;
    localparam int OFS_OE    = 3;
    localparam int OFS_INSEL = 4;

    // one decoded write operation, at most one bit set per cycle
    typedef struct packed {
        logic load;
        logic raise;
        logic lower;
        logic oe;
        logic insel;
    } wr_op_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R7: output equals the input from two edges earlier
    p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_bus_map.sv
module gpio_bus_map #(
    parameter int WIDTH     = 16,
    parameter bit MIRROR    = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] lines_out,
    input  logic [WIDTH-1:0] lines_in,
    output logic [WIDTH-1:0] bus_out
);

    localparam int  NBYTES  = WIDTH / 8;
    localparam bit  SWAP_OK = BYTE_SWAP && (WIDTH == 16 || WIDTH == 32);

    logic [WIDTH-1:0] wr_swapped;
    logic [WIDTH-1:0] rd_mirrored;

    // write path: swap bytes first, then mirror bits
    // read path: mirror bits first, then swap bytes (inverse of write path)
    generate
        if (SWAP_OK) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign wr_swapped[8*b +: 8] = bus_in[8*(NBYTES-1-b) +: 8];
                assign bus_out[8*b +: 8]    = rd_mirrored[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_noswap
            assign wr_swapped = bus_in;
            assign bus_out    = rd_mirrored;
        end

        if (MIRROR) begin : g_mirror
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign lines_out[i]   = wr_swapped[WIDTH-1-i];
                assign rd_mirrored[i] = lines_in[WIDTH-1-i];
            end
        end else begin : g_straight
            assign lines_out   = wr_swapped;
            assign rd_mirrored = lines_in;
        end
    endgenerate

endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs
    import gpio_mmio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_op_t           op,
    input  logic [WIDTH-1:0] wval,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);

    logic [WIDTH-1:0] latch_d;
    logic [WIDTH-1:0] dir_d;

    always_comb begin
        latch_d = latch_q;
        dir_d   = dir_q;
        if (op.load)  latch_d = wval;
        if (op.raise) latch_d = latch_q | wval;
        if (op.lower) latch_d = latch_q & ~wval;
        if (op.oe)    dir_d   = wval;
        if (op.insel) dir_d   = ~wval;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            dir_q   <= dir_d;
        end
    end

    // R2: a load copies the data
    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op.load |=> (latch_q == $past(wval)));

    // R3: raise drives marked lines high and lowers none
    p_raise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op.raise |=> (((latch_q & $past(wval)) == $past(wval)) &&
                      ((latch_q & $past(latch_q)) == $past(latch_q)) &&
                      ((latch_q & ~$past(wval)) == ($past(latch_q) & ~$past(wval)))));

    // R4: lower drives marked lines low and raises none
    p_lower_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op.lower |=> (((latch_q & $past(wval)) == '0) &&
                      ((latch_q & ~$past(wval)) == ($past(latch_q) & ~$past(wval)))));

    // R5: output-enable write
    p_oe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op.oe |=> (dir_q == $past(wval)));

    // R6: input-select write is the complement
    p_insel_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op.insel |=> (dir_q == ~$past(wval)));

    // R9: no operation, no change
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == '0) |=> ($stable(latch_q) && $stable(dir_q)));

    // R2: at most one operation per cycle
    p_single_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op));

endmodule

// File: rtl/gpio_mmio_bank.sv
module gpio_mmio_bank
    import gpio_mmio_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int ADDR_W    = 3,
    parameter bit MIRROR    = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic              rsp_valid,
    output logic [WIDTH-1:0]  rsp_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);

    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
    localparam logic [ADDR_W-1:0] A_LOWER = ADDR_W'(OFS_LOWER);
    localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE);
    localparam logic [ADDR_W-1:0] A_INSEL = ADDR_W'(OFS_INSEL);

    wr_op_t           op;
    logic             rd_req;
    logic [WIDTH-1:0] wr_lines;
    logic [WIDTH-1:0] rd_lines;
    logic [WIDTH-1:0] rd_bus;
    logic [WIDTH-1:0] sync_lines;
    logic [WIDTH-1:0] latch_lines;
    logic [WIDTH-1:0] dir_lines;

    gpio_bus_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_map (
        .bus_in   (bus_wdata),
        .lines_out(wr_lines),
        .lines_in (rd_lines),
        .bus_out  (rd_bus)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(sync_lines)
    );

    gpio_line_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wval   (wr_lines),
        .latch_q(latch_lines),
        .dir_q  (dir_lines)
    );

    // write decode
    always_comb begin
        op = '0;
        if (bus_valid && bus_write) begin
            op.load  = (bus_addr == A_LOAD);
            op.raise = (bus_addr == A_RAISE);
            op.lower = (bus_addr == A_LOWER);
            op.oe    = (bus_addr == A_OE);
            op.insel = (bus_addr == A_INSEL);
        end
    end

    assign rd_req = bus_valid && !bus_write;

    // read select in line order; the map turns it into bus order
    always_comb begin
        unique case (bus_addr)
            A_LOAD:  rd_lines = sync_lines;
            A_RAISE: rd_lines = latch_lines;
            A_OE:    rd_lines = dir_lines;
            A_INSEL: rd_lines = ~dir_lines;
            default: rd_lines = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_bus;
        end
    end

    assign pad_out = latch_lines;
    assign pad_oe  = dir_lines;

    // R1: outputs idle when reset releases
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((pad_out == '0) && (pad_oe == '0)));

    // R12: strobe follows read requests
    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rsp_valid && $stable(rsp_rdata)));

    // R9: unmapped offsets read zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (bus_addr > A_INSEL || bus_addr == A_LOWER)) |=> (rsp_rdata == '0));

endmodule

// File: tb/gpio_mmio_bank_tb.sv
module gpio_mmio_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] pad_in = '0;

    logic         rv0, rv1, rv2;
    logic [W-1:0] rd0, rd1, rd2;
    logic [W-1:0] po0, po1, po2;
    logic [W-1:0] oe0, oe1, oe2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mmio_bank #(.WIDTH(W), .MIRROR(1'b0), .BYTE_SWAP(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rv0), .rsp_rdata(rd0),
        .pad_in(pad_in), .pad_out(po0), .pad_oe(oe0));

    gpio_mmio_bank #(.WIDTH(W), .MIRROR(1'b1), .BYTE_SWAP(1'b0)) u_dut_mir (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rv1), .rsp_rdata(rd1),
        .pad_in(pad_in), .pad_out(po1), .pad_oe(oe1));

    gpio_mmio_bank #(.WIDTH(W), .MIRROR(1'b0), .BYTE_SWAP(1'b1)) u_dut_swp (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rv2), .rsp_rdata(rd2),
        .pad_in(pad_in), .pad_out(po2), .pad_oe(oe2));

    function automatic logic [W-1:0] rev(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) y[i] = x[W-1-i];
        return y;
    endfunction

    function automatic logic [W-1:0] bsw(input logic [W-1:0] x);
        return {x[7:0], x[15:8]};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // straight, mirrored (R10) and byte-swapped (R11) views of one bus-order value
    task automatic chk3(input string tag, input logic [W-1:0] g0, input logic [W-1:0] g1,
                        input logic [W-1:0] g2, input logic [W-1:0] exp);
        chk(tag, g0, exp);
        chk({tag, "/R10"}, g1, rev(exp));
        chk({tag, "/R11"}, g2, bsw(exp));
    endtask

    // starts and ends at a falling edge
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // reads the same value from all three views (direction, latch readback)
    task automatic rd_same(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
        rd(a);
        chk(tag, rd0, exp);
        chk({tag, "/R10"}, rd1, exp);
        chk({tag, "/R11"}, rd2, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        logic [W-1:0] lfsr;
        logic [W-1:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk3("R1 pad_out", po0, po1, po2, '0);
        chk3("R1 pad_oe", oe0, oe1, oe2, '0);
        rd_same("R1 oe read", 3'd3, '0);
        rd_same("R1 insel read", 3'd4, '1);

        // R2 load sweep, R8 latch readback
        for (int k = 0; k < 256; k++) begin
            logic [W-1:0] v;
            v = W'(k * 257) ^ W'(k << 3) ^ 16'h5A0F;
            wr(3'd0, v);
            chk3("R2 load", po0, po1, po2, v);
            if (k % 16 == 0) rd_same("R8 latch read", 3'd1, v);
        end

        // R3 / R4 raise and lower, arithmetic model in bus order
        wr(3'd0, 16'h0F0F);
        model = 16'h0F0F;
        lfsr = 16'hACE1;
        for (int k = 0; k < 128; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k[0]) begin
                wr(3'd1, lfsr);
                model = model | lfsr;
                chk3("R3 raise", po0, po1, po2, model);
            end else begin
                wr(3'd2, lfsr);
                model = model & ~lfsr;
                chk3("R4 lower", po0, po1, po2, model);
            end
        end
        wr(3'd1, 16'h0000);
        chk3("R3 zero raise", po0, po1, po2, model);
        wr(3'd2, 16'h0000);
        chk3("R4 zero lower", po0, po1, po2, model);

        // R5 / R6 direction pair
        for (int k = 0; k < 32; k++) begin
            logic [W-1:0] v;
            v = W'(k * 16'h0841) ^ 16'h3C96;
            wr(3'd3, v);
            chk3("R5 oe", oe0, oe1, oe2, v);
            rd_same("R5 insel complement", 3'd4, ~v);
            wr(3'd4, v);
            chk3("R6 insel", oe0, oe1, oe2, ~v);
            rd_same("R6 oe complement", 3'd3, ~v);
        end

        // R7 synchronizer latency: old, old, new; with lines as outputs too
        wr(3'd3, 16'hFFFF);
        hold = '0;
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] p;
            p = W'(k * 16'h1357) ^ 16'hC3A5;
            pad_in = p;
            bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd0;
            @(negedge clk);
            chk3("R7 first read old", rd0, rd1, rd2, hold);
            @(negedge clk);
            chk3("R7 second read old", rd0, rd1, rd2, hold);
            @(negedge clk);
            chk3("R7 third read new", rd0, rd1, rd2, p);
            bus_valid = 1'b0;
            hold = p;
        end

        // R8 latch read is independent of pads
        wr(3'd0, 16'h1234);
        pad_in = 16'hEDCB;
        repeat (3) @(negedge clk);
        rd_same("R8 latch vs pad", 3'd1, 16'h1234);
        rd(3'd0);
        chk3("R8 pad via load offset", rd0, rd1, rd2, 16'hEDCB);

        // R9 unmapped and write-only offsets
        wr(3'd3, 16'h00FF);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 16'hFFFF);
            chk3("R9 pad_out unchanged", po0, po1, po2, 16'h1234);
            chk3("R9 pad_oe unchanged", oe0, oe1, oe2, 16'h00FF);
            rd_same("R9 unmapped read", 3'(a), '0);
        end
        rd_same("R9 lower reads zero", 3'd2, '0);

        // R12 strobe timing and data hold
        rd(3'd1);
        checks++;
        if (rv0 !== 1'b1) begin
            errors++;
            $display("FAIL R12 strobe after read actual=%b expected=1", rv0);
        end
        wr(3'd0, 16'h0000);
        checks++;
        if (rv0 !== 1'b0) begin
            errors++;
            $display("FAIL R12 strobe after write actual=%b expected=0", rv0);
        end
        chk("R12 data held", rd0, 16'h1234);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule